// File: doc/BRIEF.md
# ATA PIO Strobe Timer

This block produces the read and write strobes for single programmed-I/O transfers on a parallel ATA host. The host has two channels with two devices each, so it serves four timing units. A unit is selected as `{channel, device}`, which gives the index 2 × channel + device. Each unit owns one 16-bit timing word. Its low byte times reads and its high byte times writes. Every count is one period of the host bus clock, about 30 ns at 33 MHz.

Software writes the timing words and a control byte through a byte-wide write port. Each bit of the control byte lets a unit run with DMA timing and stops the sampling of IORDY for that unit. A change to the control byte does not take effect while the host's write buffers report busy.

For each accepted request, the cycle engine drives the strobe low for the programmed active width. When sampling is enabled for the unit, it holds the strobe low while IORDY is low. It then keeps the strobe high for the programmed recovery time and only then accepts the next request.

Top module: `ata_strobe_timer`

## Requirements
- R1: After reset both strobes are high, `busy` and `done` are low, every bit of `unit_dma_en` is clear, and every timing word is 0x0000. A cycle on an unprogrammed unit therefore has an active width of 17 clocks and a recovery of 16 clocks.
- R2: A read request accepted at a clock edge drives `dior_n` low from the next clock on, for the active width. `diow_n` stays high, and the two strobes are never low together.
- R3: A write request takes its timing from the high byte of the unit's word (byte address base + 1) and strobes `diow_n` instead of `dior_n`.
- R4: The low nibble of a timing byte is a code c. It gives an active width of 17 − c clocks, so code 0xF gives the minimum of 2 and code 0x0 gives the maximum of 17.
- R5: The high nibble of a timing byte is a code c. It gives a recovery of 16 − c clocks, counted from the rising strobe up to and including the `done` clock, so the range is 1 to 16.
- R6: The word of unit u sits at byte address 0x44 + 2u (low byte) and 0x45 + 2u (high byte). A write to one unit's word leaves every other unit's timing unchanged.
- R7: When the unit's enable bit is clear and IORDY is low at the end of the programmed active width, the strobe stays low until the first clock in which IORDY is high. The active phase then lasts max(active width, clocks until IORDY is high).
- R8: When the unit's enable bit is set, IORDY is ignored and the active phase lasts exactly the programmed width.
- R9: The control byte sits at address 0x42, and unit u's enable bit is bit 4 + u. A control write made while `wbuf_busy[0]` or `wbuf_busy[1]` is set is held back. It reaches `unit_dma_en` at the first clock edge at which both bits are clear. When the buffers are idle, the write takes effect at its own edge.
- R10: A timing word written while a cycle is running affects only cycles accepted after that write.
- R11: `busy` is high from the clock after acceptance until recovery ends. `done` is high for exactly one clock, the last clock of recovery. A request that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Byte write strobe for the register port |
| cfg_addr | input | 8 | Byte address of the register write |
| cfg_wdata | input | 8 | Byte write data |
| wbuf_busy | input | 2 | Write-buffer busy flags; any set bit defers control writes |
| req_valid | input | 1 | Request for one programmed-I/O cycle |
| req_unit | input | 2 | Unit index, {channel, device} |
| req_write | input | 1 | 1 for a write cycle, 0 for a read cycle |
| iordy | input | 1 | Device ready, already synchronous to clk |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| busy | output | 1 | A cycle is in its active or recovery phase |
| done | output | 1 | One-clock pulse in the last recovery clock |
| unit_dma_en | output | 4 | Applied per-unit DMA/IORDY-bypass enables |

## Verification
The strobe falls one clock after the accepting edge and stays low for the decoded active width, or longer under an IORDY hold. Recovery begins the clock after the strobe rises and ends with `done`. `unit_dma_en` changes one edge after a control write when the buffers are idle. When the buffers are busy, it changes one edge after both busy bits clear. The bench samples every output on the falling clock edge. A driver task pushes the expected strobe kind, active width and recovery length for each request into a queue. A monitor measures the low run and the recovery run edge by edge and compares them when it sees `done`. Checks on the register port are taken one falling edge after the edge at which the update is due.

// File: rtl/ata_strobe_pkg.sv
// Package: shared types and timing-code decoders for the ATA PIO strobe timer.
// Assumes timing codes are 4-bit nibbles stored as "max minus count".
package ata_strobe_pkg;

    localparam int CNT_W = 5;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_ACTIVE  = 2'd1,
        PH_RECOVER = 2'd2
    } phase_t;

    typedef struct packed {
        logic [3:0] rec_code;
        logic [3:0] act_code;
    } tbyte_t;

    // Active strobe width in clocks from its code (17 minus code).
    function automatic logic [CNT_W-1:0] act_clocks(input logic [3:0] code);
        return CNT_W'(17) - {1'b0, code};
    endfunction

    // Recovery length in clocks from its code (16 minus code).
    function automatic logic [CNT_W-1:0] rec_clocks(input logic [3:0] code);
        return CNT_W'(16) - {1'b0, code};
    endfunction

endpackage

// File: rtl/ata_timing_regs.sv
// Module: per-unit timing words and the control byte with a deferred update.
// Assumes byte writes. Unit u owns addresses TIMING_BASE+2u (read byte) and
// TIMING_BASE+2u+1 (write byte). A control write is held while any write-buffer
// busy flag is set.
module ata_timing_regs #(
    parameter int NUM_UNITS   = 4,
    parameter int ADDR_W      = 8,
    parameter int TIMING_BASE = 'h44,
    parameter int CTL_ADDR    = 'h42,
    parameter int CTL_EN_LSB  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [ADDR_W-1:0]          cfg_addr,
    input  logic [7:0]                 cfg_wdata,
    input  logic [1:0]                 wbuf_busy,
    output logic [NUM_UNITS-1:0][15:0] timing_words,
    output logic [NUM_UNITS-1:0]       unit_en
);

    localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_ADDR);

    logic                 ctl_hit;
    logic                 bufs_idle;
    logic                 pend_vld;
    logic [NUM_UNITS-1:0] pend_en;

    assign ctl_hit   = cfg_we && (cfg_addr == CTL_A);
    assign bufs_idle = (wbuf_busy == 2'b00);

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(TIMING_BASE + 2 * u);
        localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(TIMING_BASE + 2 * u + 1);

        // Byte-wise update of this unit's timing word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                timing_words[u] <= '0;
            end else if (cfg_we && cfg_addr == LO_A) begin
                timing_words[u][7:0] <= cfg_wdata;
            end else if (cfg_we && cfg_addr == HI_A) begin
                timing_words[u][15:8] <= cfg_wdata;
            end
        end
    end

    // Control byte: apply at once when the buffers are idle, otherwise hold it pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unit_en  <= '0;
            pend_en  <= '0;
            pend_vld <= 1'b0;
        end else if (ctl_hit && bufs_idle) begin
            unit_en  <= cfg_wdata[CTL_EN_LSB +: NUM_UNITS];
            pend_vld <= 1'b0;
        end else if (ctl_hit) begin
            pend_en  <= cfg_wdata[CTL_EN_LSB +: NUM_UNITS];
            pend_vld <= 1'b1;
        end else if (pend_vld && bufs_idle) begin
            unit_en  <= pend_en;
            pend_vld <= 1'b0;
        end
    end

endmodule

// File: rtl/ata_cycle_engine.sv
// Module: runs one programmed-I/O cycle at a time: active, optional IORDY hold,
// then recovery. Assumes iordy is already synchronous to clk. The timing byte
// and the IORDY-sampling choice are latched at acceptance.
module ata_cycle_engine
    import ata_strobe_pkg::*;
#(
    parameter int NUM_UNITS = 4,
    localparam int UNIT_W   = $clog2(NUM_UNITS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [UNIT_W-1:0]          req_unit,
    input  logic                       req_write,
    input  logic [NUM_UNITS-1:0][15:0] timing_words,
    input  logic [NUM_UNITS-1:0]       unit_en,
    input  logic                       iordy,
    output logic                       dior_n,
    output logic                       diow_n,
    output logic                       busy,
    output logic                       done
);

    phase_t           phase;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] rec_m1;
    logic             cur_wr;
    logic             cur_chk;
    tbyte_t           sel;
    logic             accept;

    assign accept = req_valid && (phase == PH_IDLE);
    assign sel    = req_write ? tbyte_t'(timing_words[req_unit][15:8])
                              : tbyte_t'(timing_words[req_unit][7:0]);

    // Phase sequencer with a down-counter shared by the active and recovery phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            rec_m1  <= '0;
            cur_wr  <= 1'b0;
            cur_chk <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: if (accept) begin
                    phase   <= PH_ACTIVE;
                    cnt     <= act_clocks(sel.act_code) - CNT_W'(1);
                    rec_m1  <= rec_clocks(sel.rec_code) - CNT_W'(1);
                    cur_wr  <= req_write;
                    cur_chk <= !unit_en[req_unit];
                end
                PH_ACTIVE: if (cnt != '0) begin
                    cnt <= cnt - CNT_W'(1);
                end else if (!cur_chk || iordy) begin
                    phase <= PH_RECOVER;
                    cnt   <= rec_m1;
                end
                PH_RECOVER: if (cnt != '0) begin
                    cnt <= cnt - CNT_W'(1);
                end else begin
                    phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Strobes and status decoded from the phase registers.
    always_comb begin
        dior_n = !((phase == PH_ACTIVE) && !cur_wr);
        diow_n = !((phase == PH_ACTIVE) && cur_wr);
        busy   = (phase != PH_IDLE);
        done   = (phase == PH_RECOVER) && (cnt == '0);
    end

endmodule

// File: rtl/ata_strobe_timer.sv
// Module: top of the ATA PIO strobe timer, joining the register store and the
// cycle engine. Assumes four units indexed {channel, device} and one
// requester at a time.
module ata_strobe_timer #(
    parameter int NUM_UNITS   = 4,
    parameter int ADDR_W      = 8,
    parameter int TIMING_BASE = 'h44,
    parameter int CTL_ADDR    = 'h42,
    parameter int CTL_EN_LSB  = 4,
    localparam int UNIT_W     = $clog2(NUM_UNITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [7:0]           cfg_wdata,
    input  logic [1:0]           wbuf_busy,
    input  logic                 req_valid,
    input  logic [UNIT_W-1:0]    req_unit,
    input  logic                 req_write,
    input  logic                 iordy,
    output logic                 dior_n,
    output logic                 diow_n,
    output logic                 busy,
    output logic                 done,
    output logic [NUM_UNITS-1:0] unit_dma_en
);

    logic [NUM_UNITS-1:0][15:0] timing_words;

    ata_timing_regs #(
        .NUM_UNITS  (NUM_UNITS),
        .ADDR_W     (ADDR_W),
        .TIMING_BASE(TIMING_BASE),
        .CTL_ADDR   (CTL_ADDR),
        .CTL_EN_LSB (CTL_EN_LSB)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .wbuf_busy   (wbuf_busy),
        .timing_words(timing_words),
        .unit_en     (unit_dma_en)
    );

    ata_cycle_engine #(
        .NUM_UNITS(NUM_UNITS)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_unit    (req_unit),
        .req_write   (req_write),
        .timing_words(timing_words),
        .unit_en     (unit_dma_en),
        .iordy       (iordy),
        .dior_n      (dior_n),
        .diow_n      (diow_n),
        .busy        (busy),
        .done        (done)
    );

endmodule

// File: rtl/ata_strobe_timer_chk.sv
// Module: assertion checker for ata_strobe_timer, attached with bind below.
module ata_strobe_timer_chk #(
    parameter int NUM_UNITS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_write,
    input logic [1:0]           wbuf_busy,
    input logic [NUM_UNITS-1:0] unit_dma_en,
    input logic                 dior_n,
    input logic                 diow_n,
    input logic                 busy,
    input logic                 done
);

    a_r2_read_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !req_write) |=> !dior_n);

    a_r3_write_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_write) |=> !diow_n);

    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dior_n && !diow_n));

    a_r11_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!dior_n || !diow_n) |-> busy);

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy ##1 !busy);

    a_r9_ctl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (wbuf_busy != 2'b00) |=> $stable(unit_dma_en));

endmodule

bind ata_strobe_timer ata_strobe_timer_chk #(.NUM_UNITS(NUM_UNITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .wbuf_busy  (wbuf_busy),
    .unit_dma_en(unit_dma_en),
    .dior_n     (dior_n),
    .diow_n     (diow_n),
    .busy       (busy),
    .done       (done)
);

// File: tb/ata_strobe_timer_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues the expected cycle shape, the monitor measures it.
module ata_strobe_timer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [1:0] wbuf_busy = '0;
    logic       req_valid = 1'b0;
    logic [1:0] req_unit = '0;
    logic       req_write = 1'b0;
    logic       iordy = 1'b1;
    logic       dior_n, diow_n, busy, done;
    logic [3:0] unit_dma_en;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit    wr;
        int    act;
        int    rec;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    logic [15:0] tmodel [4];
    logic [3:0]  ctl_applied = '0;

    always #2.5 clk = ~clk;

    ata_strobe_timer u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .wbuf_busy(wbuf_busy), .req_valid(req_valid),
        .req_unit(req_unit), .req_write(req_write), .iordy(iordy),
        .dior_n(dior_n), .diow_n(diow_n), .busy(busy), .done(done),
        .unit_dma_en(unit_dma_en)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a >= 8'h44 && a <= 8'h4B) begin
            if (a[0]) tmodel[(a - 8'h44) >> 1][15:8] = d;
            else      tmodel[(a - 8'h44) >> 1][7:0]  = d;
        end
    endtask

    // Driver: queue the expected shape, issue the request, optionally hold IORDY low.
    task automatic do_cycle(input int u, input bit wr, input int hold, input string tag);
        logic [7:0] b;
        exp_t e;
        int a;
        b = wr ? tmodel[u][15:8] : tmodel[u][7:0];
        a = 17 - int'(b[3:0]);
        e.wr  = wr;
        e.rec = 16 - int'(b[7:4]);
        e.act = (hold > a && !ctl_applied[u]) ? hold : a;
        e.tag = tag;
        sb_q.push_back(e);
        if (hold > 0) iordy = 1'b0;
        req_valid = 1'b1; req_unit = 2'(u); req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        if (hold > 0) begin
            repeat (hold - 1) @(negedge clk);
            iordy = 1'b1;
        end
        while (busy) @(negedge clk);
    endtask

    // Monitor: measure strobe-low run and recovery run, compare with the queue head.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && (!dior_n || !diow_n)) begin
                bit wr;
                int act;
                int rec;
                exp_t e;
                wr  = !diow_n;
                act = 0;
                while (!dior_n || !diow_n) begin
                    act++;
                    @(negedge clk);
                end
                rec = 0;
                forever begin
                    rec++;
                    if (done || rec > 40) break;
                    @(negedge clk);
                end
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R11", "unexpected cycle", 1, 0);
                end else begin
                    e = sb_q.pop_front();
                    chk(wr == e.wr, e.tag, "strobe is write", int'(wr), int'(e.wr));
                    chk(act == e.act, e.tag, "active clocks", act, e.act);
                    chk(rec == e.rec, e.tag, "recovery clocks", rec, e.rec);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
        $finish;
    end

    initial begin
        bit seen_low;
        for (int i = 0; i < 4; i++) tmodel[i] = 16'h0000;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(dior_n == 1'b1, "R1", "dior_n after reset", int'(dior_n), 1);
        chk(diow_n == 1'b1, "R1", "diow_n after reset", int'(diow_n), 1);
        chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
        chk(unit_dma_en == 4'h0, "R1", "unit_dma_en after reset", int'(unit_dma_en), 0);
        do_cycle(0, 1'b0, 0, "R1");
        do_cycle(2, 1'b1, 0, "R1");

        // R2 R3 R4 R5: unit 0 read A=12 R=1, write A=7 R=13
        cfg_write(8'h44, 8'hF5);
        cfg_write(8'h45, 8'h3A);
        do_cycle(0, 1'b0, 0, "R4");
        do_cycle(0, 1'b1, 0, "R3");
        do_cycle(0, 1'b0, 0, "R2");

        // R6: unit 3 read A=2 R=16 (R4 min), write A=17 R=1 (R5 min); unit 2 untouched
        cfg_write(8'h4A, 8'h0F);
        cfg_write(8'h4B, 8'hF0);
        do_cycle(3, 1'b0, 0, "R6");
        do_cycle(3, 1'b1, 0, "R5");
        do_cycle(2, 1'b0, 0, "R6");

        // R10: timing change mid-cycle applies only to the next cycle
        cfg_write(8'h46, 8'h88);
        fork
            do_cycle(1, 1'b0, 0, "R10");
            begin
                repeat (3) @(negedge clk);
                cfg_write(8'h46, 8'h2E);
            end
        join
        do_cycle(1, 1'b0, 0, "R10");

        // R7: IORDY hold longer and shorter than the programmed width
        do_cycle(2, 1'b0, 25, "R7");
        do_cycle(0, 1'b0, 5, "R7");

        // R9: control write deferred while write buffers busy
        wbuf_busy = 2'b10;
        cfg_write(8'h42, 8'h40);
        repeat (3) @(negedge clk);
        chk(unit_dma_en == 4'h0, "R9", "enable held while busy", int'(unit_dma_en), 0);
        wbuf_busy = 2'b01;
        @(negedge clk);
        chk(unit_dma_en == 4'h0, "R9", "enable held bit0 busy", int'(unit_dma_en), 0);
        wbuf_busy = 2'b00;
        @(negedge clk);
        chk(unit_dma_en == 4'h4, "R9", "enable after buffers idle", int'(unit_dma_en), 4);
        cfg_write(8'h42, 8'h50);
        chk(unit_dma_en == 4'h5, "R9", "immediate enable", int'(unit_dma_en), 5);
        ctl_applied = 4'h5;

        // R8: enabled unit ignores IORDY
        do_cycle(2, 1'b0, 25, "R8");

        // R11: busy level and an ignored request during a cycle
        fork
            do_cycle(3, 1'b0, 0, "R11");
            begin
                repeat (2) @(negedge clk);
                chk(busy == 1'b1, "R11", "busy during active", int'(busy), 1);
                req_valid = 1'b1; req_unit = 2'd0; req_write = 1'b1;
                @(negedge clk);
                req_valid = 1'b0;
            end
        join
        seen_low = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!dior_n || !diow_n) seen_low = 1'b1;
        end
        chk(!seen_low, "R11", "strobe after ignored request", int'(seen_low), 0);
        chk(sb_q.size() == 0, "R11", "pending expected cycles", sb_q.size(), 0);

        summary();
        $finish;
    end

endmodule